// File: doc/BRIEF.md
# Multi-Port Pipe Buffer Access Hub

This block is a register-mapped front end to a packet buffer pool that is split into numbered pipes. Three access ports share the pool. The general port serves the CPU only. Each of the two DMA-capable ports serves the CPU and also carries a request/acknowledge pair for a DMA engine. Each port has four registers:

- a 16-bit data window that appends words to, or pops words from, the selected pipe;
- a pipe-select register;
- a control register;
- a transfer counter, which has an effect on the DMA ports only.

Each pipe buffer is owned either by the CPU or by the serial engine. The control register can hand the selected pipe to the engine, and a per-pipe release input hands it back. The block enforces the access rules. Pipe 0 is reachable only from the general port. No pipe may be held by two ports. While a port's DMA function runs, that port's pipe selection is locked. Every pipe keeps its own read and write pointers. These pointers restart whenever the pipe is newly selected.

Top module: `pipe_port_hub`

## Requirements
- R1: The register word address is `{port, reg}`. The port field sits in bits 7:2 and takes the values 4 (general), 5 (DMA port A) and 6 (DMA port B), which puts the data windows at 0x10, 0x14 and 0x18. The reg field sits in bits 1:0: 0 = data, 1 = select, 2 = control, 3 = counter. A read issued in one cycle returns `reg_rdata` with `reg_rack` high in the next cycle.
- R2: After reset, `reg_rdata`, `reg_rack` and `dma_req` are 0. The general port holds pipe 0. The DMA ports hold no pipe. Select readback is bit 15 = error, bit 14 = holding, bits 2:0 = pipe.
- R3: Data written through a port's data window is returned by that port's data reads in the same order. Each pipe has 64 words.
- R4: An accepted select write resets both pointers of the chosen pipe, so the next read returns the first word written after that select.
- R5: Pipe 0 is reachable only through the general port. Writing select 0 on a DMA port releases its pipe. A data read on that port then returns 0 with `reg_rerr` = 1.
- R6: DMA request and acknowledge exist only on the DMA ports. On the general port, control bits 1 (DMA enable) and 2 (direction) always read back 0.
- R7: Writing 1 to control bit 0 hands the selected pipe to the engine, and control readback bit 0 then reads 1. While the engine owns the pipe, CPU data writes are dropped and CPU data reads return 0 with `reg_rerr` = 1. Pulsing `eng_release[p]` returns pipe p to the CPU.
- R8: While DMA is enabled on a port, select writes to that port are ignored.
- R9: Writes to one port's registers never change another port's registers.
- R10: A select that names a pipe held by another port is rejected. The held pipe is unchanged and select bit 15 is set. The next accepted select clears bit 15.
- R11: The counter register on a DMA port loads a 16-bit count. Each accepted DMA word (`dma_ack` while `dma_req`) decrements it. The word that takes the count from 1 to 0 clears DMA enable, which drops `dma_req` and releases the select lock.
- R12: With direction = 1, an accepted acknowledge writes `dma_wdata` into the pipe. With direction = 0, it pops the next word onto `dma_rdata` in the following cycle.
- R13: While DMA is enabled on a port, CPU data accesses to that port are ignored. A read returns `reg_rerr` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, one cycle after reg_rd |
| reg_rack | output | 1 | Read response valid |
| reg_rerr | output | 1 | Read data invalid (blocked data access) |
| dma_req | output | 2 | DMA request, DMA ports A and B |
| dma_ack | input | 2 | DMA acknowledge, one word per cycle |
| dma_wdata | input | 16 | DMA write data |
| dma_rdata | output | 16 | DMA read data, one cycle after ack |
| eng_release | input | 8 | Per-pipe return of ownership to the CPU |

## Verification
Register reads are due exactly one cycle after the strobe. The bench drives the strobe at a falling edge and samples `reg_rdata`/`reg_rerr` at the next falling edge. Register writes, ownership changes and acknowledges take effect at the edge that samples them. `dma_req`, the counter and the lock state are therefore checked at the falling edge after that edge, and `dma_rdata` is checked at the same point. A full sweep over all eight pipes on the general port, and over pipes 1 to 7 on a DMA port, checks ordering and pointer restart with arithmetic patterns.

// File: rtl/pph_pkg.sv
package pph_pkg;
   typedef enum logic [1:0] {
      RK_DATA = 2'd0,
      RK_SEL  = 2'd1,
      RK_CTL  = 2'd2,
      RK_CNT  = 2'd3
   } reg_kind_e;

   localparam int unsigned PORT_COUNT   = 3;
   localparam logic [5:0]  PORT_FIELD0  = 6'h04;

   localparam int unsigned SEL_ERR_BIT  = 15;
   localparam int unsigned SEL_HELD_BIT = 14;
   localparam int unsigned CTL_OWN_BIT  = 0;
   localparam int unsigned CTL_EN_BIT   = 1;
   localparam int unsigned CTL_DIR_BIT  = 2;
endpackage

// File: rtl/pph_port.sv
module pph_port #(
   parameter int unsigned NPIPE  = 8,
   parameter int unsigned DW     = 16,
   parameter int unsigned CNTW   = 16,
   parameter bit          IS_DMA = 1'b0,
   localparam int unsigned PW    = $clog2(NPIPE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_we,
   input  logic             ctl_we,
   input  logic             cnt_we,
   input  logic [DW-1:0]    wdata,
   input  logic [NPIPE-1:0] other_busy,
   input  logic             xfer_done,
   output logic             held,
   output logic [PW-1:0]    pipe,
   output logic             dma_en,
   output logic             dma_dir,
   output logic             sel_err,
   output logic [CNTW-1:0]  tcount,
   output logic             ptr_clr,
   output logic             handoff
);
   import pph_pkg::*;

   logic [PW-1:0] req_pipe;
   logic          release_req;
   logic          conflict;
   logic          accept;

   assign req_pipe    = wdata[PW-1:0];
   assign release_req = IS_DMA && (req_pipe == '0);
   assign conflict    = other_busy[req_pipe] && !release_req;
   assign accept      = sel_we && !dma_en && !conflict;
   assign ptr_clr     = accept && !release_req;
   assign handoff     = ctl_we && wdata[CTL_OWN_BIT] && held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held    <= !IS_DMA;
         pipe    <= '0;
         sel_err <= 1'b0;
      end else if (sel_we && !dma_en) begin
         if (conflict) begin
            sel_err <= 1'b1;
         end else begin
            pipe    <= req_pipe;
            held    <= !release_req;
            sel_err <= 1'b0;
         end
      end
   end

   generate
      if (IS_DMA) begin : g_dma
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dma_en  <= 1'b0;
               dma_dir <= 1'b0;
               tcount  <= '0;
            end else begin
               if (xfer_done && tcount != '0) tcount <= tcount - 1'b1;
               if (cnt_we) tcount <= wdata[CNTW-1:0];
               if (xfer_done && tcount == CNTW'(1)) dma_en <= 1'b0;
               if (ctl_we) begin
                  dma_en  <= wdata[CTL_EN_BIT];
                  dma_dir <= wdata[CTL_DIR_BIT];
               end
            end
         end

         assert_dma_stop_R11 : assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_done && tcount == CNTW'(1) && !ctl_we) |=> !dma_en);
         assert_count_step_R11 : assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_done && !cnt_we && tcount != '0) |=> tcount == $past(tcount) - 1'b1);
      end else begin : g_plain
         assign dma_en  = 1'b0;
         assign dma_dir = 1'b0;
         assign tcount  = '0;
      end
   endgenerate

   assert_sel_lock_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (sel_we && dma_en) |=> ($stable(pipe) && $stable(held)));
   assert_reject_keeps_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (sel_we && !dma_en && conflict) |=> ($stable(pipe) && sel_err));
endmodule

// File: rtl/pph_pool.sv
module pph_pool #(
   parameter int unsigned NPIPE = 8,
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DW    = 16,
   parameter int unsigned NPORT = 3,
   localparam int unsigned PW   = $clog2(NPIPE),
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned WORDS = NPIPE * DEPTH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPORT-1:0]           acc_rd,
   input  logic [NPORT-1:0]           acc_wr,
   input  logic [NPORT-1:0][PW-1:0]   acc_pipe,
   input  logic [NPORT-1:0][DW-1:0]   acc_wdata,
   input  logic [NPORT-1:0]           ptr_clr,
   input  logic [NPORT-1:0][PW-1:0]   clr_pipe,
   input  logic [NPORT-1:0]           handoff,
   input  logic [NPIPE-1:0]           eng_release,
   output logic [NPORT-1:0][DW-1:0]   rd_word,
   output logic [NPIPE-1:0]           eng_owned
);
   logic [DW-1:0]           mem [WORDS];
   logic [NPIPE-1:0][AW-1:0] rptr;
   logic [NPIPE-1:0][AW-1:0] wptr;
   logic [NPIPE-1:0]         set_mask;

   always_comb begin
      set_mask = '0;
      for (int i = 0; i < NPORT; i++)
         if (handoff[i]) set_mask[acc_pipe[i]] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr      <= '0;
         wptr      <= '0;
         eng_owned <= '0;
      end else begin
         for (int i = 0; i < NPORT; i++) begin
            if (acc_wr[i]) wptr[acc_pipe[i]] <= wptr[acc_pipe[i]] + 1'b1;
            if (acc_rd[i]) rptr[acc_pipe[i]] <= rptr[acc_pipe[i]] + 1'b1;
            if (ptr_clr[i]) begin
               rptr[clr_pipe[i]] <= '0;
               wptr[clr_pipe[i]] <= '0;
            end
         end
         eng_owned <= (eng_owned | set_mask) & ~eng_release;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NPORT; i++)
         if (acc_wr[i]) mem[{acc_pipe[i], wptr[acc_pipe[i]]}] <= acc_wdata[i];
   end

   generate
      for (genvar g = 0; g < NPORT; g++) begin : g_rd
         assign rd_word[g] = mem[{acc_pipe[g], rptr[acc_pipe[g]]}];

         assert_owned_nowrite_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            acc_wr[g] |-> !eng_owned[acc_pipe[g]]);
         assert_owned_noread_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            acc_rd[g] |-> !eng_owned[acc_pipe[g]]);
      end
      for (genvar p = 0; p < NPIPE; p++) begin : g_own
         assert_release_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            eng_release[p] |=> !eng_owned[p]);
      end
   endgenerate
endmodule

// File: rtl/pipe_port_hub.sv
module pipe_port_hub #(
   parameter int unsigned NPIPE = 8,
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DW    = 16,
   parameter int unsigned CNTW  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [7:0]       reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic             reg_rack,
   output logic             reg_rerr,
   output logic [1:0]       dma_req,
   input  logic [1:0]       dma_ack,
   input  logic [DW-1:0]    dma_wdata,
   output logic [DW-1:0]    dma_rdata,
   input  logic [NPIPE-1:0] eng_release
);
   import pph_pkg::*;

   localparam int unsigned NPORT = PORT_COUNT;
   localparam int unsigned PW    = $clog2(NPIPE);

   initial begin
      if (NPIPE < 2 || (NPIPE & (NPIPE - 1)) != 0) $error("NPIPE must be a power of two >= 2");
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) $error("DEPTH must be a power of two >= 2");
      if (DW < 16) $error("DW must be at least 16");
      if (CNTW > DW || CNTW < 1) $error("CNTW must be 1..DW");
      if (PW > 13) $error("pipe field overlaps status bits");
   end

   reg_kind_e              kind;
   logic [NPORT-1:0]       hit, sel_we, ctl_we, cnt_we;
   logic [NPORT-1:0]       held, dma_en, dma_dir, sel_err, ptr_clr, handoff;
   logic [NPORT-1:0]       reachable, cpu_rd, cpu_wr, xfer_done, acc_rd, acc_wr;
   logic [NPORT-1:0][PW-1:0]   pipe;
   logic [NPORT-1:0][CNTW-1:0] tcount;
   logic [NPORT-1:0][NPIPE-1:0] held_mask, other_busy;
   logic [NPORT-1:0][DW-1:0]   acc_wdata, rd_word;
   logic [NPIPE-1:0]       eng_owned;
   logic [1:0]             dma_go;
   logic [DW-1:0]          nxt_rdata;
   logic                   nxt_rerr;

   assign kind = reg_kind_e'(reg_addr[1:0]);

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_port
         assign hit[i]    = (reg_addr[7:2] == PORT_FIELD0 + 6'(i));
         assign sel_we[i] = reg_wr && hit[i] && kind == RK_SEL;
         assign ctl_we[i] = reg_wr && hit[i] && kind == RK_CTL;
         assign cnt_we[i] = reg_wr && hit[i] && kind == RK_CNT;
         assign held_mask[i] = held[i] ? (NPIPE'(1) << pipe[i]) : '0;
         assign reachable[i] = held[i] && !eng_owned[pipe[i]];
         assign cpu_rd[i] = reg_rd && hit[i] && kind == RK_DATA && !dma_en[i] && reachable[i];
         assign cpu_wr[i] = reg_wr && hit[i] && kind == RK_DATA && !dma_en[i] && reachable[i];

         if (i == 0) begin : g_cpu_only
            assign xfer_done[i] = 1'b0;
            assign acc_rd[i]    = cpu_rd[i];
            assign acc_wr[i]    = cpu_wr[i];
            assign acc_wdata[i] = reg_wdata;
         end else begin : g_with_dma
            assign dma_req[i-1]   = dma_en[i] && reachable[i];
            assign dma_go[i-1]    = dma_ack[i-1] && dma_req[i-1];
            assign xfer_done[i]   = dma_go[i-1];
            assign acc_rd[i]      = cpu_rd[i] || (dma_go[i-1] && !dma_dir[i]);
            assign acc_wr[i]      = cpu_wr[i] || (dma_go[i-1] && dma_dir[i]);
            assign acc_wdata[i]   = dma_go[i-1] ? dma_wdata : reg_wdata;

            assert_dport_no_pipe0_R5 : assert property (@(posedge clk) disable iff (!rst_n)
               held[i] |-> pipe[i] != '0);
            assert_cpu_blocked_R13 : assert property (@(posedge clk) disable iff (!rst_n)
               (dma_en[i] && reg_wr && hit[i] && kind == RK_DATA && !dma_go[i-1]) |-> !acc_wr[i]);
         end

         pph_port #(
            .NPIPE (NPIPE),
            .DW    (DW),
            .CNTW  (CNTW),
            .IS_DMA(i != 0)
         ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_we    (sel_we[i]),
            .ctl_we    (ctl_we[i]),
            .cnt_we    (cnt_we[i]),
            .wdata     (reg_wdata),
            .other_busy(other_busy[i]),
            .xfer_done (xfer_done[i]),
            .held      (held[i]),
            .pipe      (pipe[i]),
            .dma_en    (dma_en[i]),
            .dma_dir   (dma_dir[i]),
            .sel_err   (sel_err[i]),
            .tcount    (tcount[i]),
            .ptr_clr   (ptr_clr[i]),
            .handoff   (handoff[i])
         );
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < NPORT; i++) begin
         other_busy[i] = '0;
         for (int k = 0; k < NPORT; k++)
            if (k != i) other_busy[i] = other_busy[i] | held_mask[k];
      end
   end

   pph_pool #(
      .NPIPE(NPIPE),
      .DEPTH(DEPTH),
      .DW   (DW),
      .NPORT(NPORT)
   ) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_rd     (acc_rd),
      .acc_wr     (acc_wr),
      .acc_pipe   (pipe),
      .acc_wdata  (acc_wdata),
      .ptr_clr    (ptr_clr),
      .clr_pipe   (pipe_req_vec()),
      .handoff    (handoff),
      .eng_release(eng_release),
      .rd_word    (rd_word),
      .eng_owned  (eng_owned)
   );

   function automatic logic [NPORT-1:0][PW-1:0] pipe_req_vec();
      logic [NPORT-1:0][PW-1:0] v;
      for (int i = 0; i < NPORT; i++) v[i] = reg_wdata[PW-1:0];
      return v;
   endfunction

   always_comb begin
      nxt_rdata = '0;
      nxt_rerr  = 1'b0;
      for (int i = 0; i < NPORT; i++) begin
         if (hit[i]) begin
            case (kind)
               RK_DATA: begin
                  if (!dma_en[i] && reachable[i]) nxt_rdata = rd_word[i];
                  else nxt_rerr = 1'b1;
               end
               RK_SEL: begin
                  nxt_rdata[PW-1:0]     = pipe[i];
                  nxt_rdata[SEL_HELD_BIT] = held[i];
                  nxt_rdata[SEL_ERR_BIT]  = sel_err[i];
               end
               RK_CTL: begin
                  nxt_rdata[CTL_OWN_BIT] = held[i] && eng_owned[pipe[i]];
                  nxt_rdata[CTL_EN_BIT]  = dma_en[i];
                  nxt_rdata[CTL_DIR_BIT] = dma_dir[i];
               end
               default: nxt_rdata[CNTW-1:0] = tcount[i];
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         reg_rack  <= 1'b0;
         reg_rerr  <= 1'b0;
         dma_rdata <= '0;
      end else begin
         reg_rack <= reg_rd;
         if (reg_rd) begin
            reg_rdata <= nxt_rdata;
            reg_rerr  <= nxt_rerr;
         end
         for (int j = 0; j < 2; j++)
            if (dma_go[j] && !dma_dir[j+1]) dma_rdata <= rd_word[j+1];
      end
   end

   assert_read_ack_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rack);
   assert_unique_pipe_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      ((held_mask[0] & held_mask[1]) | (held_mask[0] & held_mask[2]) |
       (held_mask[1] & held_mask[2])) == '0);
   assert_isolation_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !hit[1] && !dma_go[0]) |=> ($stable(pipe[1]) && $stable(dma_en[1]) && $stable(tcount[1])));
endmodule

// File: tb/pipe_port_hub_tb.sv
module pipe_port_hub_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        reg_rack, reg_rerr;
   logic [1:0]  dma_req;
   logic [1:0]  dma_ack = '0;
   logic [15:0] dma_wdata = '0;
   logic [15:0] dma_rdata;
   logic [7:0]  eng_release = '0;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   pipe_port_hub u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rack(reg_rack), .reg_rerr(reg_rerr), .dma_req(dma_req),
      .dma_ack(dma_ack), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
      .eng_release(eng_release)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [15:0] d, output logic e);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata; e = reg_rerr;
      checks++;
      if (reg_rack !== 1'b1) begin
         failures++;
         $display("FAIL R1 rack actual=%b expected=1", reg_rack);
      end
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp, input logic exp_err);
      logic [15:0] d;
      logic e;
      bus_rd(a, d, e);
      chk(req, {15'd0, e, d}, {15'd0, exp_err, exp});
   endtask

   task automatic dma_word(input int j, input logic [15:0] d, output logic [15:0] rd);
      @(negedge clk);
      dma_ack[j] = 1'b1; dma_wdata = d;
      @(negedge clk);
      rd = dma_rdata;
      dma_ack[j] = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 rdata", reg_rdata, 0);
      chk("R2 rack", reg_rack, 0);
      chk("R2 dma_req", dma_req, 0);
      rd_chk("R2 general select", 8'h11, 16'h4000, 0);
      rd_chk("R2 dmaA select", 8'h15, 16'h0000, 0);

      // R3/R4/R1 sweep over all pipes on the general port
      for (int p = 0; p < 8; p++) begin
         bus_wr(8'h11, 16'(p));
         for (int k = 0; k < 5; k++) bus_wr(8'h10, 16'((p << 8) | (k * 3 + 1)));
         for (int k = 0; k < 5; k++) rd_chk("R3 order", 8'h10, 16'((p << 8) | (k * 3 + 1)), 0);
         bus_wr(8'h11, 16'(p));
         rd_chk("R4 pointer restart", 8'h10, 16'((p << 8) | 1), 0);
      end
      bus_wr(8'h11, 16'h0000);

      // R1 DMA port B data window over pipes 1..7
      for (int p = 1; p < 8; p++) begin
         bus_wr(8'h19, 16'(p));
         bus_wr(8'h18, 16'(16'hB000 + p * 7));
         rd_chk("R1 dmaB window", 8'h18, 16'(16'hB000 + p * 7), 0);
      end
      bus_wr(8'h19, 16'h0000);

      // R5 pipe 0 not reachable from DMA port
      bus_wr(8'h15, 16'h0000);
      rd_chk("R5 release select", 8'h15, 16'h0000, 0);
      rd_chk("R5 data blocked", 8'h14, 16'h0000, 1);

      // R10 conflicts
      bus_wr(8'h15, 16'h0003);
      rd_chk("R10 first hold", 8'h15, 16'h4003, 0);
      bus_wr(8'h19, 16'h0003);
      rd_chk("R10 dmaB rejected", 8'h19, 16'h8000, 0);
      bus_wr(8'h11, 16'h0003);
      rd_chk("R10 general rejected", 8'h11, 16'hC000, 0);
      bus_wr(8'h19, 16'h0004);
      rd_chk("R10 error cleared", 8'h19, 16'h4004, 0);
      bus_wr(8'h11, 16'h0000);
      rd_chk("R10 general cleared", 8'h11, 16'h4000, 0);

      // R9 isolation
      bus_wr(8'h1B, 16'h0009);
      bus_wr(8'h1A, 16'h0004);
      rd_chk("R9 dmaA select kept", 8'h15, 16'h4003, 0);
      rd_chk("R9 dmaA control kept", 8'h16, 16'h0000, 0);
      rd_chk("R9 dmaA count kept", 8'h17, 16'h0000, 0);
      chk("R9 no request", dma_req, 0);

      // R11/R12 DMA write, R8 lock, R13 CPU blocked
      bus_wr(8'h17, 16'h0003);
      bus_wr(8'h16, 16'h0006);
      chk("R11 request up", dma_req, 2'b01);
      rd_chk("R13 cpu read blocked", 8'h14, 16'h0000, 1);
      bus_wr(8'h14, 16'hDEAD);
      bus_wr(8'h15, 16'h0005);
      rd_chk("R8 select locked", 8'h15, 16'h4003, 0);
      for (int k = 0; k < 3; k++) begin
         dma_word(0, 16'(16'hA000 + k), w);
         rd_chk("R11 count", 8'h17, 16'(2 - k), 0);
      end
      chk("R11 request down", dma_req, 2'b00);
      rd_chk("R11 enable cleared", 8'h16, 16'h0004, 0);
      rd_chk("R12 dma write data", 8'h14, 16'hA000, 0);

      // R12 DMA read
      bus_wr(8'h17, 16'h0002);
      bus_wr(8'h16, 16'h0002);
      dma_word(0, 16'h0000, w);
      chk("R12 dma read 1", w, 16'hA001);
      dma_word(0, 16'h0000, w);
      chk("R12 dma read 2", w, 16'hA002);
      chk("R11 request done", dma_req, 2'b00);
      bus_wr(8'h15, 16'h0006);
      rd_chk("R11 lock released", 8'h15, 16'h4006, 0);

      // R6 general port has no DMA
      bus_wr(8'h12, 16'h0006);
      rd_chk("R6 general control", 8'h12, 16'h0000, 0);
      chk("R6 no request", dma_req, 2'b00);

      // R7 ownership
      bus_wr(8'h11, 16'h0005);
      bus_wr(8'h10, 16'h0055);
      bus_wr(8'h12, 16'h0001);
      rd_chk("R7 owned", 8'h12, 16'h0001, 0);
      bus_wr(8'h10, 16'h0099);
      rd_chk("R7 owned read", 8'h10, 16'h0000, 1);
      @(negedge clk); eng_release = 8'h20;
      @(negedge clk); eng_release = 8'h00;
      rd_chk("R7 returned", 8'h12, 16'h0000, 0);
      bus_wr(8'h10, 16'h0077);
      rd_chk("R7 first word", 8'h10, 16'h0055, 0);
      rd_chk("R7 dropped write", 8'h10, 16'h0077, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule